// File: doc/BRIEF.md
# Multicontext Configuration Command Controller

This block sequences the control lines of a configuration memory that holds eight contexts. Each cycle it takes one request from one of two sources. The first source is an external command/context pair qualified by a valid strobe. The second is an internal change strobe with a context number, raised by user logic that counts cycles per context. The controller turns each request into timed patterns on one-hot wordlines, two plateline level codes, a write enable and a complementary pair of array power enables.

A power detector input drives two sequences. When the supply comes up, the controller performs a recall: the first plateline goes high while the second stays low, and only then is array power switched on. When the supply ramps down, the controller pulls both platelines low before it removes power. It keeps track of the context that is currently active. A context switch takes a fixed six cycles, and user logic cannot issue switch requests until the configuration is marked as loaded. Contexts other than the active one can be written in the background while the active one keeps running.

Top module: `mctx_cfg_ctrl`

## Requirements
- R1: After reset the array is off: pwr_en=0, pwr_en_n=1, both plateline codes LOW (0), wl=0, we=0, active_ctx=0, busy=1. While off, every command except recall (code 4) is ignored.
- R2: A rising pdet, or command code 4 while off, starts recall. For RC_LEN cycles the outputs are pl1=HIGH (2), pl2=LOW (0) and pwr_en=0. They are followed by one cycle with pl1=HIGH and pwr_en=1, pwr_en_n=0. The block then goes idle.
- R3: A falling pdet (from any state except off), or command code 5 while idle, gives one cycle with both platelines LOW, pwr_en=1 and wl=0. Power is then removed (pwr_en=0, pwr_en_n=1). A switch that is in flight is abandoned and active_ctx keeps its old value.
- R4: While idle, busy=0, pwr_en=1 and both plateline codes are HALF (1).
- R5: A switch request (command code 2, or the internal strobe) to a context other than the active one is sampled at clock edge 0. busy is 1 after edges 0 to 5. wl shows the one-hot target only in the cycle after edge 5. active_ctx takes the new value at edge 6.
- R6: Requests that arrive while busy=1 are dropped, not queued.
- R7: A switch request for the context that is already active leaves busy, wl, we and the platelines unchanged.
- R8: The internal strobe is ignored while cfg_done=0. External commands are not affected by cfg_done.
- R9: When ext_cmd_vld and int_chg are sampled in the same cycle, the external request is served and the internal one is lost.
- R10: A background program (command code 3) of a context that is not active drives wl one-hot on that context, we=1 and both platelines HIGH for PROG_LEN cycles. It leaves active_ctx unchanged.
- R11: A background program that names the active context is rejected: bg_err=1 for exactly one cycle, and we and wl stay 0.
- R12: Command code 1 (shift-through) raises shift_en for one cycle. Command code 6 (test) raises test_mode for one cycle. Codes 0 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_cmd_vld | input | 1 | External command valid |
| ext_cmd | input | 3 | External command code |
| ext_ctx | input | CTX_W | External context number |
| int_chg | input | 1 | Internal context-change strobe |
| int_ctx | input | CTX_W | Internal target context |
| cfg_done | input | 1 | Configuration-loaded flag; enables int_chg |
| pdet | input | 1 | Power detector, 1 = supply good |
| wl | output | 2**CTX_W | One-hot wordlines |
| we | output | 1 | Write enable |
| pl1 | output | 2 | First plateline code (0 LOW, 1 HALF, 2 HIGH) |
| pl2 | output | 2 | Second plateline code |
| pwr_en | output | 1 | Array power enable |
| pwr_en_n | output | 1 | Complement of pwr_en |
| shift_en | output | 1 | Serial shift-through pulse |
| test_mode | output | 1 | Test command pulse |
| bg_err | output | 1 | Rejected background program pulse |
| busy | output | 1 | Not idle |
| active_ctx | output | CTX_W | Currently active context |

## Verification
The bench builds the block with its default parameters: CTX_W=3, SW_LAT=6, RC_LEN=2 and PROG_LEN=2. With these values every source/target pair of the eight contexts can be swept, alternating between the external and internal request paths. It can also background-program every context from two different active contexts. The six-cycle switch window is short enough to check cycle by cycle, including a second request injected in the middle of a switch and a power loss during a switch.

// File: rtl/mctx_pkg.sv
package mctx_pkg;
  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_SHIFT  = 3'd1,
    CMD_SWITCH = 3'd2,
    CMD_PROG   = 3'd3,
    CMD_RECALL = 3'd4,
    CMD_PWROFF = 3'd5,
    CMD_TEST   = 3'd6,
    CMD_RSVD   = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    PL_LOW  = 2'd0,
    PL_HALF = 2'd1,
    PL_HIGH = 2'd2
  } pl_e;

  typedef enum logic [2:0] {
    S_OFF, S_RC_PL, S_RC_PWR, S_IDLE, S_SW, S_PROG, S_PD
  } st_e;
endpackage

// File: rtl/mctx_req_sel.sv
module mctx_req_sel import mctx_pkg::*; #(
  parameter int CTX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_cmd_vld,
  input  logic [2:0]       ext_cmd,
  input  logic [CTX_W-1:0] ext_ctx,
  input  logic             int_chg,
  input  logic [CTX_W-1:0] int_ctx,
  input  logic             cfg_done,
  input  logic             pdet,
  output cmd_e             req_cmd,
  output logic [CTX_W-1:0] req_ctx,
  output logic             pwr_up,
  output logic             pwr_dn
);
  logic pdet_q;

  // external pins win; internal strobe only once configuration is loaded
  always_comb begin
    req_cmd = CMD_NOP;
    req_ctx = '0;
    if (ext_cmd_vld) begin
      req_cmd = cmd_e'(ext_cmd);
      req_ctx = ext_ctx;
    end else if (int_chg && cfg_done) begin
      req_cmd = CMD_SWITCH;
      req_ctx = int_ctx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pdet_q <= 1'b0;
    else     pdet_q <= pdet;
  end

  assign pwr_up = pdet & ~pdet_q;
  assign pwr_dn = ~pdet & pdet_q;
endmodule

// File: rtl/mctx_seq.sv
module mctx_seq import mctx_pkg::*; #(
  parameter int CTX_W    = 3,
  parameter int SW_LAT   = 6,
  parameter int RC_LEN   = 2,
  parameter int PROG_LEN = 2,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cmd_e             req_cmd,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic             pwr_up,
  input  logic             pwr_dn,
  output st_e              st_n,
  output logic [CNT_W-1:0] cnt_n,
  output logic [CTX_W-1:0] tgt_n,
  output logic             shf_n,
  output logic             tst_n,
  output logic             err_n,
  output logic [CTX_W-1:0] active
);
  st_e              st;
  logic [CNT_W-1:0] cnt;
  logic [CTX_W-1:0] tgt;
  logic [CTX_W-1:0] act_n;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    tgt_n = tgt;
    act_n = active;
    shf_n = 1'b0;
    tst_n = 1'b0;
    err_n = 1'b0;
    if (pwr_dn && st != S_OFF) begin
      st_n  = S_PD;
      cnt_n = '0;
    end else begin
      case (st)
        S_OFF: if (pwr_up || req_cmd == CMD_RECALL) begin
          st_n  = S_RC_PL;
          cnt_n = CNT_W'(1);
        end
        S_RC_PL: begin
          if (cnt == CNT_W'(RC_LEN)) begin
            st_n  = S_RC_PWR;
            cnt_n = '0;
          end else cnt_n = cnt + CNT_W'(1);
        end
        S_RC_PWR: st_n = S_IDLE;
        S_IDLE: begin
          case (req_cmd)
            CMD_SHIFT: shf_n = 1'b1;
            CMD_TEST:  tst_n = 1'b1;
            CMD_SWITCH: if (req_ctx != active) begin
              st_n  = S_SW;
              cnt_n = CNT_W'(1);
              tgt_n = req_ctx;
            end
            CMD_PROG: begin
              if (req_ctx == active) err_n = 1'b1;
              else begin
                st_n  = S_PROG;
                cnt_n = CNT_W'(1);
                tgt_n = req_ctx;
              end
            end
            CMD_RECALL: begin
              st_n  = S_RC_PL;
              cnt_n = CNT_W'(1);
            end
            CMD_PWROFF: st_n = S_PD;
            default: ;
          endcase
        end
        S_SW: begin
          if (cnt == CNT_W'(SW_LAT)) begin
            st_n  = S_IDLE;
            cnt_n = '0;
            act_n = tgt;
          end else cnt_n = cnt + CNT_W'(1);
        end
        S_PROG: begin
          if (cnt == CNT_W'(PROG_LEN)) begin
            st_n  = S_IDLE;
            cnt_n = '0;
          end else cnt_n = cnt + CNT_W'(1);
        end
        S_PD:    st_n = S_OFF;
        default: st_n = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_OFF;
      cnt    <= '0;
      tgt    <= '0;
      active <= '0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      tgt    <= tgt_n;
      active <= act_n;
    end
  end
endmodule

// File: rtl/mctx_out.sv
module mctx_out import mctx_pkg::*; #(
  parameter int CTX_W  = 3,
  parameter int SW_LAT = 6,
  parameter int CNT_W  = 4,
  localparam int NCTX  = 1 << CTX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  st_e              st_n,
  input  logic [CNT_W-1:0] cnt_n,
  input  logic [CTX_W-1:0] tgt_n,
  input  logic             shf_n,
  input  logic             tst_n,
  input  logic             err_n,
  output logic [NCTX-1:0]  wl,
  output logic             we,
  output logic [1:0]       pl1,
  output logic [1:0]       pl2,
  output logic             pwr_en,
  output logic             pwr_en_n,
  output logic             shift_en,
  output logic             test_mode,
  output logic             bg_err,
  output logic             busy
);
  pl_e             pl1_d, pl2_d;
  logic            pwr_d, we_d, sel_d;
  logic [NCTX-1:0] wl_d;

  // decode from next state so every output leaves a flop
  always_comb begin
    pl1_d = PL_LOW;
    pl2_d = PL_LOW;
    pwr_d = 1'b0;
    we_d  = 1'b0;
    sel_d = 1'b0;
    case (st_n)
      S_RC_PL:  pl1_d = PL_HIGH;
      S_RC_PWR: begin pl1_d = PL_HIGH; pwr_d = 1'b1; end
      S_IDLE:   begin pl1_d = PL_HALF; pl2_d = PL_HALF; pwr_d = 1'b1; end
      S_SW: begin
        pl1_d = PL_HALF;
        pl2_d = PL_HALF;
        pwr_d = 1'b1;
        sel_d = (cnt_n == CNT_W'(SW_LAT));
      end
      S_PROG: begin
        pl1_d = PL_HIGH;
        pl2_d = PL_HIGH;
        pwr_d = 1'b1;
        we_d  = 1'b1;
        sel_d = 1'b1;
      end
      S_PD:    pwr_d = 1'b1;
      default: ;
    endcase
  end

  for (genvar i = 0; i < NCTX; i++) begin : g_wl
    assign wl_d[i] = sel_d && (tgt_n == CTX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wl        <= '0;
      we        <= 1'b0;
      pl1       <= PL_LOW;
      pl2       <= PL_LOW;
      pwr_en    <= 1'b0;
      pwr_en_n  <= 1'b1;
      shift_en  <= 1'b0;
      test_mode <= 1'b0;
      bg_err    <= 1'b0;
      busy      <= 1'b1;
    end else begin
      wl        <= wl_d;
      we        <= we_d;
      pl1       <= pl1_d;
      pl2       <= pl2_d;
      pwr_en    <= pwr_d;
      pwr_en_n  <= ~pwr_d;
      shift_en  <= shf_n;
      test_mode <= tst_n;
      bg_err    <= err_n;
      busy      <= (st_n != S_IDLE);
    end
  end
endmodule

// File: rtl/mctx_cfg_ctrl.sv
module mctx_cfg_ctrl import mctx_pkg::*; #(
  parameter int CTX_W    = 3,
  parameter int SW_LAT   = 6,
  parameter int RC_LEN   = 2,
  parameter int PROG_LEN = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ext_cmd_vld,
  input  logic [2:0]              ext_cmd,
  input  logic [CTX_W-1:0]        ext_ctx,
  input  logic                    int_chg,
  input  logic [CTX_W-1:0]        int_ctx,
  input  logic                    cfg_done,
  input  logic                    pdet,
  output logic [(1<<CTX_W)-1:0]   wl,
  output logic                    we,
  output logic [1:0]              pl1,
  output logic [1:0]              pl2,
  output logic                    pwr_en,
  output logic                    pwr_en_n,
  output logic                    shift_en,
  output logic                    test_mode,
  output logic                    bg_err,
  output logic                    busy,
  output logic [CTX_W-1:0]        active_ctx
);
  localparam int CNT_W = $clog2(SW_LAT + RC_LEN + PROG_LEN + 1);

  cmd_e             req_cmd;
  logic [CTX_W-1:0] req_ctx;
  logic             pwr_up, pwr_dn;
  st_e              st_n;
  logic [CNT_W-1:0] cnt_n;
  logic [CTX_W-1:0] tgt_n;
  logic             shf_n, tst_n, err_n;

  mctx_req_sel #(.CTX_W(CTX_W)) u_sel (
    .clk(clk), .rst(rst),
    .ext_cmd_vld(ext_cmd_vld), .ext_cmd(ext_cmd), .ext_ctx(ext_ctx),
    .int_chg(int_chg), .int_ctx(int_ctx), .cfg_done(cfg_done), .pdet(pdet),
    .req_cmd(req_cmd), .req_ctx(req_ctx), .pwr_up(pwr_up), .pwr_dn(pwr_dn)
  );

  mctx_seq #(.CTX_W(CTX_W), .SW_LAT(SW_LAT), .RC_LEN(RC_LEN),
             .PROG_LEN(PROG_LEN), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .req_cmd(req_cmd), .req_ctx(req_ctx),
    .pwr_up(pwr_up), .pwr_dn(pwr_dn), .st_n(st_n), .cnt_n(cnt_n),
    .tgt_n(tgt_n), .shf_n(shf_n), .tst_n(tst_n), .err_n(err_n),
    .active(active_ctx)
  );

  mctx_out #(.CTX_W(CTX_W), .SW_LAT(SW_LAT), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .st_n(st_n), .cnt_n(cnt_n), .tgt_n(tgt_n),
    .shf_n(shf_n), .tst_n(tst_n), .err_n(err_n),
    .wl(wl), .we(we), .pl1(pl1), .pl2(pl2), .pwr_en(pwr_en),
    .pwr_en_n(pwr_en_n), .shift_en(shift_en), .test_mode(test_mode),
    .bg_err(bg_err), .busy(busy)
  );
endmodule

// File: rtl/mctx_chk.sv
module mctx_chk #(
  parameter int CTX_W = 3,
  localparam int NCTX = 1 << CTX_W
) (
  input logic             clk,
  input logic             rst,
  input logic [NCTX-1:0]  wl,
  input logic             we,
  input logic [1:0]       pl1,
  input logic [1:0]       pl2,
  input logic             pwr_en,
  input logic             busy,
  input logic [CTX_W-1:0] active_ctx
);
  // R2: power only comes on after plateline 1 high, plateline 2 low
  a_r2_pl_before_pwr: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_en) |-> $past(pl1 == 2'd2 && pl2 == 2'd0));

  // R3: platelines are low in the cycle before power is removed
  a_r3_pl_low_before_off: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_en) |-> $past(pl1 == 2'd0 && pl2 == 2'd0));

  // R4: idle means mid-level platelines with power on
  a_r4_idle_half: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (pl1 == 2'd1 && pl2 == 2'd1 && pwr_en));

  // R5: at most one wordline
  a_r5_wl_onehot0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wl));

  // R5: a new active context was read on its wordline the cycle before
  a_r5_active_after_read: assert property (@(posedge clk) disable iff (rst)
    (active_ctx != $past(active_ctx)) |-> ($past(wl) == (NCTX'(1) << active_ctx)));

  // R10: a write always has exactly one wordline
  a_r10_we_has_wl: assert property (@(posedge clk) disable iff (rst)
    we |-> $onehot(wl));

  // R11: the active context is never written
  a_r11_no_write_active: assert property (@(posedge clk) disable iff (rst)
    we |-> ((wl & (NCTX'(1) << active_ctx)) == '0));
endmodule

bind mctx_cfg_ctrl mctx_chk #(.CTX_W(CTX_W)) u_chk (
  .clk(clk), .rst(rst), .wl(wl), .we(we), .pl1(pl1), .pl2(pl2),
  .pwr_en(pwr_en), .busy(busy), .active_ctx(active_ctx)
);

// File: tb/tb_mctx_cfg_ctrl.sv
module tb_mctx_cfg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CTX_W = 3;
  localparam int NCTX = 1 << CTX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_cmd_vld = 1'b0;
  logic [2:0] ext_cmd = '0;
  logic [CTX_W-1:0] ext_ctx = '0;
  logic int_chg = 1'b0;
  logic [CTX_W-1:0] int_ctx = '0;
  logic cfg_done = 1'b0;
  logic pdet = 1'b0;
  logic [NCTX-1:0] wl;
  logic we, pwr_en, pwr_en_n, shift_en, test_mode, bg_err, busy;
  logic [1:0] pl1, pl2;
  logic [CTX_W-1:0] active_ctx;

  int n_chk = 0;
  int n_fail = 0;
  int exp_act = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mctx_cfg_ctrl dut (
    .clk(clk), .rst(rst), .ext_cmd_vld(ext_cmd_vld), .ext_cmd(ext_cmd),
    .ext_ctx(ext_ctx), .int_chg(int_chg), .int_ctx(int_ctx),
    .cfg_done(cfg_done), .pdet(pdet), .wl(wl), .we(we), .pl1(pl1),
    .pl2(pl2), .pwr_en(pwr_en), .pwr_en_n(pwr_en_n), .shift_en(shift_en),
    .test_mode(test_mode), .bg_err(bg_err), .busy(busy),
    .active_ctx(active_ctx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr();
    ext_cmd_vld = 1'b0;
    ext_cmd = '0;
    ext_ctx = '0;
    int_chg = 1'b0;
    int_ctx = '0;
  endtask

  task automatic ext(int cmd, int ctx);
    ext_cmd_vld = 1'b1;
    ext_cmd = 3'(cmd);
    ext_ctx = CTX_W'(ctx);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // R2 recall sequence, starting with stimulus already applied before edge 0
  task automatic recall_seq();
    tick(); clr();
    for (int j = 0; j < 2; j++) begin
      chk("R2 pl1 high", pl1, 2); chk("R2 pl2 low", pl2, 0);
      chk("R2 power off", pwr_en, 0); chk("R2 power_n", pwr_en_n, 1);
      tick();
    end
    chk("R2 power on", pwr_en, 1); chk("R2 power_n off", pwr_en_n, 0);
    chk("R2 pl1 still high", pl1, 2);
    tick();
    chk("R4 pl1 half", pl1, 1); chk("R4 pl2 half", pl2, 1);
    chk("R4 idle", busy, 0); chk("R4 power", pwr_en, 1);
  endtask

  // R5/R7 switch from one source, inputs applied at a negedge
  task automatic do_switch(bit use_int, int tgt);
    if (use_int) begin int_chg = 1'b1; int_ctx = CTX_W'(tgt); end
    else ext(2, tgt);
    tick(); clr();
    if (tgt == exp_act) begin
      for (int j = 0; j < 7; j++) begin
        chk("R7 busy", busy, 0); chk("R7 wl", wl, 0);
        chk("R7 pl1", pl1, 1); chk("R7 active", active_ctx, exp_act);
        tick();
      end
    end else begin
      for (int j = 0; j < 6; j++) begin
        chk("R5 wl timing", wl, (j == 5) ? (32'd1 << tgt) : 32'd0);
        chk("R5 active held", active_ctx, exp_act);
        chk("R5 busy", busy, 1);
        tick();
      end
      chk("R5 active new", active_ctx, tgt);
      chk("R5 idle again", busy, 0);
      chk("R5 wl off", wl, 0);
      exp_act = tgt;
    end
  endtask

  task automatic prog_sweep();
    for (int t = 0; t < NCTX; t++) begin
      ext(3, t);
      tick(); clr();
      if (t == exp_act) begin
        chk("R11 err pulse", bg_err, 1); chk("R11 we", we, 0);
        chk("R11 wl", wl, 0); chk("R11 busy", busy, 0);
        tick();
        chk("R11 err one cycle", bg_err, 0);
      end else begin
        for (int j = 0; j < 2; j++) begin
          chk("R10 we", we, 1); chk("R10 wl", wl, 32'd1 << t);
          chk("R10 pl1", pl1, 2); chk("R10 pl2", pl2, 2);
          chk("R10 busy", busy, 1); chk("R10 no err", bg_err, 0);
          tick();
        end
        chk("R10 we off", we, 0); chk("R10 wl off", wl, 0);
        chk("R10 idle", busy, 0); chk("R10 active kept", active_ctx, exp_act);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 pwr_en", pwr_en, 0); chk("R1 pwr_en_n", pwr_en_n, 1);
    chk("R1 pl1", pl1, 0); chk("R1 pl2", pl2, 0);
    chk("R1 wl", wl, 0); chk("R1 we", we, 0);
    chk("R1 active", active_ctx, 0); chk("R1 busy", busy, 1);
    // R1 commands ignored while off
    ext(2, 5); tick(); clr(); tick();
    chk("R1 off ignores switch", active_ctx, 0); chk("R1 still off", pwr_en, 0);
    chk("R1 wl while off", wl, 0);

    pdet = 1'b1;
    recall_seq();

    // R5/R7 all pairs, alternating sources
    cfg_done = 1'b1;
    for (int a = 0; a < NCTX; a++)
      for (int b = 0; b < NCTX; b++) begin
        do_switch(((a + b) % 2) == 1, a);
        do_switch(((a + b) % 2) == 0, b);
      end

    // R6 request during a switch is dropped
    begin
      int first = (exp_act + 1) % NCTX;
      int second = (exp_act + 2) % NCTX;
      ext(2, first); tick(); clr(); tick();
      ext(2, second); tick(); clr();
      repeat (4) tick();
      chk("R6 first target wins", active_ctx, first);
      chk("R6 idle", busy, 0);
      repeat (2) tick();
      chk("R6 not queued", busy, 0);
      chk("R6 active kept", active_ctx, first);
      exp_act = first;
    end

    // R8 internal strobe gated by cfg_done
    cfg_done = 1'b0;
    int_chg = 1'b1; int_ctx = CTX_W'((exp_act + 3) % NCTX);
    tick(); clr();
    chk("R8 gated busy", busy, 0);
    repeat (7) tick();
    chk("R8 gated active", active_ctx, exp_act);
    do_switch(1'b0, (exp_act + 3) % NCTX);
    cfg_done = 1'b1;

    // R9 external wins over internal in the same cycle
    begin
      int ta = (exp_act + 1) % NCTX;
      int tb = (exp_act + 4) % NCTX;
      ext(2, ta); int_chg = 1'b1; int_ctx = CTX_W'(tb);
      tick(); clr();
      repeat (6) tick();
      chk("R9 external served", active_ctx, ta);
      exp_act = ta;
    end

    // R10/R11 background programming from two active contexts
    prog_sweep();
    do_switch(1'b0, 6);
    prog_sweep();

    // R12 shift, test and no-op codes
    ext(1, 0); tick(); clr();
    chk("R12 shift pulse", shift_en, 1); chk("R12 shift no test", test_mode, 0);
    chk("R12 shift idle", busy, 0);
    tick(); chk("R12 shift one cycle", shift_en, 0);
    ext(6, 0); tick(); clr();
    chk("R12 test pulse", test_mode, 1); chk("R12 test no shift", shift_en, 0);
    tick(); chk("R12 test one cycle", test_mode, 0);
    ext(0, 2); tick(); ext(7, 3); tick(); clr();
    chk("R12 nop shift", shift_en, 0); chk("R12 nop test", test_mode, 0);
    chk("R12 nop busy", busy, 0); chk("R12 nop wl", wl, 0);
    chk("R12 nop active", active_ctx, exp_act);

    // R3 power off by command, then recall by command
    ext(5, 0); tick(); clr();
    chk("R3 cmd pl1 low", pl1, 0); chk("R3 cmd pl2 low", pl2, 0);
    chk("R3 cmd power still on", pwr_en, 1); chk("R3 cmd wl", wl, 0);
    tick();
    chk("R3 cmd power off", pwr_en, 0); chk("R3 cmd power_n", pwr_en_n, 1);
    ext(4, 0);
    recall_seq();
    chk("R2 active kept over recall", active_ctx, exp_act);

    // R3 supply loss during a switch
    ext(2, (exp_act + 1) % NCTX); tick(); clr(); tick();
    pdet = 1'b0; tick();
    chk("R3 pl1 low", pl1, 0); chk("R3 pl2 low", pl2, 0);
    chk("R3 power held", pwr_en, 1); chk("R3 wl", wl, 0);
    tick();
    chk("R3 power off", pwr_en, 0); chk("R3 power_n", pwr_en_n, 1);
    repeat (6) tick();
    chk("R3 switch abandoned", active_ctx, exp_act);
    pdet = 1'b1;
    recall_seq();
    chk("R3 active after restore", active_ctx, exp_act);

    done = 1;
    summary();
  end
endmodule